// File: doc/BRIEF.md
# Paged Pointer Address Generator

This block keeps the program counter and three general pointer registers of a small 8-bit processor core. It turns one operation per clock into a 16-bit memory address. The supported operations are:

- stepping the program counter for an instruction fetch;
- forming a data address from a pointer and a signed byte offset;
- auto-indexing, where the pointer moves by the offset around the access;
- swapping a pointer with the program counter, which gives subroutine calls and returns without a stack;
- writing a pointer one byte at a time.

All address arithmetic is confined to the low 12 bits. A fetch or an offset therefore wraps inside the current 4 KB page, and the top four bits come unchanged from the base register.

The surrounding decoder presents an operation code, a pointer number, an offset byte and a data byte in the same cycle. The resulting address and its valid strobe appear registered after the next rising clock edge. The program counter is register 0 of the same file. Register updates take effect at that same edge.

Top module: `paged_ptr_agu`

## Requirements
- R1: While reset is asserted and after it is released, all four registers are zero, `addr_vld_o` is 0 and `addr_o` is 0x0000.
- R2: Operation code 1 (fetch) increments the program counter first, modulo 4096 in bits 11:0, with bits 15:12 unchanged. The new value appears on `addr_o` one cycle later with `addr_vld_o` high. For example, 0x3FFF steps to 0x3000.
- R3: Operation code 2 (relative) outputs the base register's bits 15:12 concatenated with (base bits 11:0 plus the sign-extended offset) modulo 4096. Pointer 0 as base means the current program counter.
- R4: A relative access leaves all four registers unchanged.
- R5: Operation code 3 (auto-index) with pointer 1–3 and a negative offset (bit 7 set) first writes the page-wrapped sum into the pointer, then outputs that new value.
- R6: Operation code 3 with pointer 1–3 and a non-negative offset outputs the old pointer value, then writes the page-wrapped sum into the pointer.
- R7: Operation code 3 with pointer 0 behaves as a relative access and leaves the program counter unchanged.
- R8: Operation code 4 (swap) with pointer 1–3 exchanges all 16 bits of that pointer with the program counter in one cycle. With pointer 0 it changes nothing.
- R9: Operation codes 5 and 6 write `data_i` into bits 7:0 or bits 15:8 respectively of the selected register (pointer 0 being the program counter) and keep the other byte. Apart from a swap, no operation changes more than one register per cycle.
- R10: `addr_vld_o` is high only in the cycle after operation codes 1, 2 or 3. After operation code 0, 4, 5, 6 or the unused code 7, `addr_vld_o` is low and `addr_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation code: 0 idle, 1 fetch, 2 relative, 3 auto-index, 4 swap, 5 load low byte, 6 load high byte |
| ptr_sel_i | input | 2 | Register number; 0 is the program counter |
| disp_i | input | 8 | Signed offset byte |
| data_i | input | 8 | Byte written by the load operations |
| addr_o | output | 16 | Registered memory address |
| addr_vld_o | output | 1 | High in the cycle that `addr_o` carries a new address |

## Verification
The bound checker watches, on every cycle, that:

- fetches stay inside their page and land on the new program counter;
- relative accesses leave the register file intact;
- auto-indexing places the address before or after the pointer update according to the offset's sign;
- swaps move both values;
- only a swap ever changes two registers;
- the strobe follows only the three addressing operations.

The exact wrapped values at a page edge, the negative-offset arithmetic, the inert swap and auto-index on pointer 0, and the effect of byte loads can only be shown by the bench's scenarios. There, a behavioural model predicts every output and register read-back.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  localparam int unsigned OP_W = 3;

  localparam logic [OP_W-1:0] OP_IDLE  = 3'd0;
  localparam logic [OP_W-1:0] OP_FETCH = 3'd1;
  localparam logic [OP_W-1:0] OP_REL   = 3'd2;
  localparam logic [OP_W-1:0] OP_AUTO  = 3'd3;
  localparam logic [OP_W-1:0] OP_SWAP  = 3'd4;
  localparam logic [OP_W-1:0] OP_LDLO  = 3'd5;
  localparam logic [OP_W-1:0] OP_LDHI  = 3'd6;
endpackage

// File: rtl/ppa_rst_sync.sv
// Asserts reset at once, removes it after two clock edges.
module ppa_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ppa_page_add.sv
// Adds a sign-extended byte to the in-page part of an address.
// The page number bits pass straight through.
module ppa_page_add #(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 12,
  parameter int unsigned DW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] off_i,
  output logic [AW-1:0] sum_o
);
  localparam int unsigned EXT_W = PW - DW;

  logic [PW-1:0] off_ext;
  logic [PW-1:0] low_sum;

  assign off_ext = {{EXT_W{off_i[DW-1]}}, off_i};
  assign low_sum = base_i[PW-1:0] + off_ext;
  assign sum_o   = {base_i[AW-1:PW], low_sum};
endmodule

// File: rtl/ppa_ptr_file.sv
// Register file: entry 0 is the program counter, the others are pointers.
module ppa_ptr_file #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NPTR = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPTR-1:0]          wen_i,
  input  logic [NPTR-1:0][AW-1:0]  wdata_i,
  output logic [NPTR-1:0][AW-1:0]  regs_o
);
  for (genvar g = 0; g < NPTR; g++) begin : g_entry
    logic [AW-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        val_q <= '0;
      else if (wen_i[g]) val_q <= wdata_i[g];
    end

    assign regs_o[g] = val_q;
  end
endmodule

// File: rtl/paged_ptr_agu.sv
module paged_ptr_agu #(
  parameter int unsigned AW        = 16,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned DW        = 8,
  parameter int unsigned NPTR      = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                op_i,
  input  logic [$clog2(NPTR)-1:0]   ptr_sel_i,
  input  logic [DW-1:0]             disp_i,
  input  logic [DW-1:0]             data_i,
  output logic [AW-1:0]             addr_o,
  output logic                      addr_vld_o
);
  import ppa_pkg::*;

  localparam int unsigned SEL_W = $clog2(NPTR);
  localparam int unsigned HI_W  = AW - DW;

  logic                     srst_n;
  logic [NPTR-1:0][AW-1:0]  regs;
  logic [NPTR-1:0]          wen;
  logic [NPTR-1:0][AW-1:0]  wdata;
  logic [AW-1:0]            pc;
  logic [AW-1:0]            base;
  logic [AW-1:0]            pc_inc;
  logic [AW-1:0]            rel_sum;
  logic                     sel_is_pc;
  logic                     off_neg;
  logic [AW-1:0]            addr_q, addr_d;
  logic                     vld_q, vld_d;

  ppa_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ppa_ptr_file #(.AW(AW), .NPTR(NPTR)) i_ptr_file (
    .clk     (clk),
    .rst_n   (srst_n),
    .wen_i   (wen),
    .wdata_i (wdata),
    .regs_o  (regs)
  );

  assign pc        = regs[0];
  assign base      = regs[ptr_sel_i];
  assign sel_is_pc = (ptr_sel_i == SEL_W'(0));
  assign off_neg   = disp_i[DW-1];

  ppa_page_add #(.AW(AW), .PW(PAGE_BITS), .DW(DW)) i_pc_step (
    .base_i (pc),
    .off_i  (DW'(1)),
    .sum_o  (pc_inc)
  );

  ppa_page_add #(.AW(AW), .PW(PAGE_BITS), .DW(DW)) i_rel_add (
    .base_i (base),
    .off_i  (disp_i),
    .sum_o  (rel_sum)
  );

  // Next-state decisions for the register file and the output stage.
  always_comb begin
    wen    = '0;
    wdata  = regs;
    addr_d = addr_q;
    vld_d  = 1'b0;
    case (op_i)
      OP_FETCH: begin
        wen[0]   = 1'b1;
        wdata[0] = pc_inc;
        addr_d   = pc_inc;
        vld_d    = 1'b1;
      end
      OP_REL: begin
        addr_d = rel_sum;
        vld_d  = 1'b1;
      end
      OP_AUTO: begin
        vld_d = 1'b1;
        if (sel_is_pc) begin
          addr_d = rel_sum;
        end else begin
          wen[ptr_sel_i]   = 1'b1;
          wdata[ptr_sel_i] = rel_sum;
          addr_d           = off_neg ? rel_sum : base;
        end
      end
      OP_SWAP: begin
        if (!sel_is_pc) begin
          wen[0]           = 1'b1;
          wen[ptr_sel_i]   = 1'b1;
          wdata[0]         = base;
          wdata[ptr_sel_i] = pc;
        end
      end
      OP_LDLO: begin
        wen[ptr_sel_i]   = 1'b1;
        wdata[ptr_sel_i] = {base[AW-1:DW], data_i};
      end
      OP_LDHI: begin
        wen[ptr_sel_i]   = 1'b1;
        wdata[ptr_sel_i] = {data_i, base[HI_W-1:0]};
      end
      default: begin
        vld_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      vld_q  <= vld_d;
    end
  end

  assign addr_o     = addr_q;
  assign addr_vld_o = vld_q;
endmodule

// File: rtl/ppa_chk.sv
module ppa_chk #(
  parameter int unsigned AW   = 16,
  parameter int unsigned PW   = 12,
  parameter int unsigned DW   = 8,
  parameter int unsigned NPTR = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               op_i,
  input logic [$clog2(NPTR)-1:0]  ptr_sel_i,
  input logic [DW-1:0]            disp_i,
  input logic [DW-1:0]            data_i,
  input logic [AW-1:0]            addr_o,
  input logic                     addr_vld_o,
  input logic [NPTR-1:0][AW-1:0]  regs
);
  import ppa_pkg::*;

  localparam int unsigned SEL_W = $clog2(NPTR);

  logic                     past_ok;
  logic [2:0]               pr_op;
  logic [SEL_W-1:0]         pr_sel;
  logic [DW-1:0]            pr_disp;
  logic [DW-1:0]            pr_data;
  logic [AW-1:0]            pr_base;
  logic [AW-1:0]            pr_pc;
  logic [NPTR-1:0][AW-1:0]  pr_regs;
  logic [NPTR-1:0]          chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      pr_op   <= '0;
      pr_sel  <= '0;
      pr_disp <= '0;
      pr_data <= '0;
      pr_base <= '0;
      pr_pc   <= '0;
      pr_regs <= '0;
    end else begin
      past_ok <= 1'b1;
      pr_op   <= op_i;
      pr_sel  <= ptr_sel_i;
      pr_disp <= disp_i;
      pr_data <= data_i;
      pr_base <= regs[ptr_sel_i];
      pr_pc   <= regs[0];
      pr_regs <= regs;
    end
  end

  always_comb begin
    for (int i = 0; i < NPTR; i++) chg[i] = (regs[i] != pr_regs[i]);
  end

  assert_fetch_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pr_op == OP_FETCH) |->
      (addr_o[AW-1:PW] == pr_pc[AW-1:PW] && addr_o == regs[0] && addr_vld_o));

  assert_rel_keeps_regs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pr_op == OP_REL) |-> (regs == pr_regs));

  assert_auto_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pr_op == OP_AUTO && pr_sel != '0 && pr_disp[DW-1]) |->
      (addr_o == regs[pr_sel]));

  assert_auto_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pr_op == OP_AUTO && pr_sel != '0 && !pr_disp[DW-1]) |->
      (addr_o == pr_base));

  assert_auto_pc_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pr_op == OP_AUTO && pr_sel == '0) |-> (regs == pr_regs));

  assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pr_op == OP_SWAP && pr_sel != '0) |->
      (regs[0] == pr_base && regs[pr_sel] == pr_pc));

  assert_load_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pr_op == OP_LDLO) |-> (regs[pr_sel][DW-1:0] == pr_data));

  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pr_op != OP_SWAP) |-> ($countones(chg) <= 1));

  assert_strobe_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && addr_vld_o) |->
      (pr_op == OP_FETCH || pr_op == OP_REL || pr_op == OP_AUTO));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !(pr_op == OP_FETCH || pr_op == OP_REL || pr_op == OP_AUTO)) |->
      (!addr_vld_o && $stable(addr_o)));
endmodule

bind paged_ptr_agu ppa_chk #(
  .AW(AW), .PW(PAGE_BITS), .DW(DW), .NPTR(NPTR)
) i_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .op_i       (op_i),
  .ptr_sel_i  (ptr_sel_i),
  .disp_i     (disp_i),
  .data_i     (data_i),
  .addr_o     (addr_o),
  .addr_vld_o (addr_vld_o),
  .regs       (regs)
);

// File: tb/test_paged_ptr_agu.sv
`timescale 1ns/1ps
module test_paged_ptr_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [1:0]  ptr_sel_i;
  logic [7:0]  disp_i;
  logic [7:0]  data_i;
  logic [15:0] addr_o;
  logic        addr_vld_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [15:0] m_r [4];
  logic [15:0] m_addr;
  logic        m_vld;

  always #2.5 clk = ~clk;

  paged_ptr_agu i_paged_ptr_agu (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .ptr_sel_i  (ptr_sel_i),
    .disp_i     (disp_i),
    .data_i     (data_i),
    .addr_o     (addr_o),
    .addr_vld_o (addr_vld_o)
  );

  function automatic logic [15:0] pg_add(input logic [15:0] b, input logic [7:0] d);
    int lo;
    lo = (int'(b[11:0]) + int'($signed(d))) & 12'hFFF;
    return {b[15:12], 12'(lo)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update(input logic [2:0] op, input logic [1:0] sel,
                              input logic [7:0] d, input logic [7:0] v);
    logic [15:0] n;
    logic [15:0] t;
    m_vld = 1'b0;
    case (op)
      3'd1: begin m_r[0] = pg_add(m_r[0], 8'd1); m_addr = m_r[0]; m_vld = 1'b1; end
      3'd2: begin m_addr = pg_add(m_r[sel], d); m_vld = 1'b1; end
      3'd3: begin
        m_vld = 1'b1;
        n = pg_add(m_r[sel], d);
        if (sel == 2'd0) m_addr = n;
        else begin
          m_addr = d[7] ? n : m_r[sel];
          m_r[sel] = n;
        end
      end
      3'd4: if (sel != 2'd0) begin t = m_r[0]; m_r[0] = m_r[sel]; m_r[sel] = t; end
      3'd5: m_r[sel][7:0] = v;
      3'd6: m_r[sel][15:8] = v;
      default: ;
    endcase
  endtask

  // One clock: drive at a falling edge, model at the rising edge, compare at the next falling edge.
  task automatic step(input logic [2:0] op, input logic [1:0] sel, input logic [7:0] d,
                      input logic [7:0] v, input string tag);
    op_i = op; ptr_sel_i = sel; disp_i = d; data_i = v;
    @(posedge clk);
    model_update(op, sel, d, v);
    @(negedge clk);
    check(addr_o == m_addr, tag, addr_o, m_addr);
    check(addr_vld_o == m_vld, tag, {15'd0, addr_vld_o}, {15'd0, m_vld});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_r[i] = 16'h0000;
    m_addr = 16'h0000; m_vld = 1'b0;
    rst_n = 1'b0; op_i = 3'd0; ptr_sel_i = 2'd0; disp_i = 8'h00; data_i = 8'h00;
    repeat (3) @(negedge clk);
    check(addr_o == 16'h0000, "R1 reset addr", addr_o, 16'h0000);
    check(!addr_vld_o, "R1 reset strobe", {15'd0, addr_vld_o}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) step(3'd0, 2'd0, 8'h00, 8'h00, "R1 idle after reset");
    for (int k = 0; k < 4; k++) step(3'd2, 2'(k), 8'h00, 8'h00, "R1 register cleared");

    // R2: sequential fetch from zero
    repeat (3) step(3'd1, 2'd0, 8'h00, 8'h00, "R2 fetch");
    // R9: load program counter bytes, then fetch across the page edge
    step(3'd6, 2'd0, 8'h00, 8'h3F, "R9 load pc high");
    step(3'd5, 2'd0, 8'h00, 8'hFE, "R9 load pc low");
    step(3'd1, 2'd0, 8'h00, 8'h00, "R2 fetch to page end");
    step(3'd1, 2'd0, 8'h00, 8'h00, "R2 fetch wraps in page");
    step(3'd1, 2'd0, 8'h00, 8'h00, "R2 fetch after wrap");

    // R3/R4: relative addressing
    step(3'd6, 2'd1, 8'h00, 8'h5F, "R9 load p1 high");
    step(3'd5, 2'd1, 8'h00, 8'hF0, "R9 load p1 low");
    step(3'd2, 2'd1, 8'h20, 8'h00, "R3 positive offset wraps");
    step(3'd2, 2'd1, 8'h80, 8'h00, "R3 offset -128");
    step(3'd2, 2'd0, 8'h05, 8'h00, "R3 pc as base");
    step(3'd2, 2'd0, 8'hFA, 8'h00, "R3 pc base negative wrap");
    step(3'd2, 2'd1, 8'h00, 8'h00, "R4 p1 unchanged");
    step(3'd1, 2'd0, 8'h00, 8'h00, "R4 pc unchanged");

    // R5/R6: auto-index on p2
    step(3'd6, 2'd2, 8'h00, 8'h10, "R9 load p2 high");
    step(3'd5, 2'd2, 8'h00, 8'h00, "R9 load p2 low");
    step(3'd2, 2'd1, 8'h00, 8'h00, "R9 p1 untouched by p2 load");
    step(3'd3, 2'd2, 8'hFF, 8'h00, "R5 pre-decrement wraps");
    step(3'd2, 2'd2, 8'h00, 8'h00, "R5 pointer updated");
    step(3'd3, 2'd2, 8'h02, 8'h00, "R6 post-increment old address");
    step(3'd2, 2'd2, 8'h00, 8'h00, "R6 pointer updated after");
    step(3'd3, 2'd2, 8'h00, 8'h00, "R6 zero offset");

    // R7: auto-index on pc
    step(3'd3, 2'd0, 8'h03, 8'h00, "R7 auto on pc");
    step(3'd3, 2'd0, 8'hF0, 8'h00, "R7 auto on pc negative");
    step(3'd1, 2'd0, 8'h00, 8'h00, "R7 pc not moved");

    // R8: swap
    step(3'd6, 2'd3, 8'h00, 8'hAB, "R9 load p3 high");
    step(3'd5, 2'd3, 8'h00, 8'hCD, "R9 load p3 low");
    step(3'd4, 2'd3, 8'h00, 8'h00, "R8 swap p3");
    step(3'd1, 2'd0, 8'h00, 8'h00, "R8 fetch from swapped pc");
    step(3'd2, 2'd3, 8'h00, 8'h00, "R8 p3 holds old pc");
    step(3'd4, 2'd3, 8'h00, 8'h00, "R8 swap back");
    step(3'd2, 2'd3, 8'h00, 8'h00, "R8 p3 after return");
    step(3'd4, 2'd0, 8'h00, 8'h00, "R8 swap pc with itself");
    step(3'd2, 2'd0, 8'h00, 8'h00, "R8 pc after null swap");

    // R10: non-addressing codes hold the address
    step(3'd1, 2'd0, 8'h00, 8'h00, "R10 fetch sets strobe");
    step(3'd0, 2'd1, 8'h44, 8'h00, "R10 idle holds");
    step(3'd7, 2'd2, 8'h44, 8'h99, "R10 unused code holds");
    step(3'd2, 2'd2, 8'h00, 8'h00, "R10 unused code wrote nothing");
    step(3'd5, 2'd1, 8'h00, 8'h12, "R10 load no strobe");
    step(3'd2, 2'd1, 8'h00, 8'h00, "R9 p1 low byte only");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule